// File: doc/BRIEF.md
# Three-Wire Serial Programming Port

This block takes a write-only control link of three wires (a serial clock, a serial data line and an active-low frame enable) and turns it into a parallel programming word. The word is held steady for the divider logic that reads it. All three wires are asynchronous to the system clock. They pass through synchronisers, and every edge is found in the system clock domain. For this reason each level of the serial clock must last at least two system clock cycles, so the serial clock runs at least four times slower than the system clock.

While the frame enable is low, each rising serial clock edge shifts one data bit into a shift register. The shift register keeps only the most recent bits. A burst of any length is accepted without complaint. When the frame enable goes back high, the shift register is copied into the output latch, and a one-cycle load pulse announces the new word. If the serial clock is low at the moment the frame enable rises, that rise also counts as a shift edge, and the data bit present at that moment goes in before the copy is made.

Top module: `serial_prog_port`

## Requirements
- R1: While the frame enable is high, serial clock edges and data have no effect: the shift register does not move, and neither word_o nor load_o changes.
- R2: While the frame enable is low, each rising serial clock edge shifts the data bit into bit 0 and moves older bits toward bit 13, so the first bit of a 14-bit burst lands in bit 13.
- R3: Only the last 14 bits shifted are kept. Bursts of any length are accepted and raise no error.
- R4: A low-to-high change of the frame enable while the serial clock is low counts as one more shift edge, using the data bit present at that moment.
- R5: A low-to-high change of the frame enable while the serial clock is high causes no shift. Only the latch update takes place.
- R6: word_o takes the shift register contents, including any shift from R4, when the frame enable rises. At all other times it holds its value.
- R7: load_o is high for exactly one system clock cycle: the first cycle in which the new word appears on word_o.
- R8: Reset clears the shift register and word_o to zero and keeps load_o low.
- R9: The shift register is not cleared between bursts. A burst shorter than 14 bits leaves the older bits shifted up above the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_en_n_i | input | 1 | Frame enable, active low, asynchronous |
| word_o | output | 14 | Latched programming word |
| load_o | output | 1 | One-cycle pulse when word_o takes a new value |

## Verification
Two events can land in the same system cycle: the extra shift and the latch copy. Both are triggered when the frame enable rises while the serial clock is low. The bench provokes this by ending bursts with the clock low, including a burst made of that single edge and nothing else. It then checks that the latched word already holds the extra bit. It also ends other bursts with the clock high and expects the word to hold no extra bit. The scoreboard forms the expected word from its own bit-level model of the shift register. That model carries state across bursts, so a wrong shift count in one burst shows up in every later word.

// File: rtl/serial_prog_pkg.sv
package serial_prog_pkg;

    localparam int SP_WORD_W      = 14;
    localparam int SP_SYNC_STAGES = 2;

    // Bit positions of the synchronised input bundle
    localparam int SP_IDX_CLK = 0;
    localparam int SP_IDX_DAT = 1;
    localparam int SP_IDX_EN  = 2;
    localparam int SP_IN_W    = 3;

    // Edge detector state: last sampled levels
    typedef struct packed {
        logic prev_clk;
        logic prev_en_n;
    } sp_edge_state_t;

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= RST_VAL;
                end else begin
                    stg_q[g] <= stg_d[g];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[LAST];

endmodule

// File: rtl/sp_edge.sv
module sp_edge
    import serial_prog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_clk_i,
    input  logic s_dat_i,
    input  logic s_en_n_i,
    output logic shift_o,
    output logic bit_o,
    output logic upd_o
);

    sp_edge_state_t st_q, st_d;
    logic clk_rise;
    logic en_rise;

    always_comb begin
        st_d.prev_clk  = s_clk_i;
        st_d.prev_en_n = s_en_n_i;

        clk_rise = s_clk_i & ~st_q.prev_clk;
        en_rise  = s_en_n_i & ~st_q.prev_en_n;

        // A normal shift needs the frame to be open; closing the frame with
        // the serial clock low is treated as one more shift edge.
        shift_o  = (clk_rise & ~s_en_n_i) | (en_rise & ~s_clk_i);
        bit_o    = s_dat_i;
        upd_o    = en_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev_clk  <= 1'b0;
            st_q.prev_en_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sp_shift_latch.sv
module sp_shift_latch #(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              upd_i,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] word;
        logic              load;
    } sl_state_t;

    sl_state_t st_q, st_d;
    logic [WORD_W-1:0] sr_next;

    always_comb begin
        if (shift_i) begin
            sr_next = {st_q.sr[WORD_W-2:0], bit_i};
        end else begin
            sr_next = st_q.sr;
        end

        st_d.sr   = sr_next;
        st_d.word = upd_i ? sr_next : st_q.word;
        st_d.load = upd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign load_o = st_q.load;

endmodule

// File: rtl/serial_prog_port.sv
module serial_prog_port
    import serial_prog_pkg::*;
#(
    parameter int WORD_W      = SP_WORD_W,
    parameter int SYNC_STAGES = SP_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_en_n_i,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o
);

    localparam logic [SP_IN_W-1:0] SYNC_RST = SP_IN_W'(1) << SP_IDX_EN;

    logic [SP_IN_W-1:0] raw_in;
    logic [SP_IN_W-1:0] sync_in;
    logic sync_clk, sync_dat, sync_en_n;
    logic shift_pulse, shift_bit, upd_pulse;

    always_comb begin
        raw_in             = '0;
        raw_in[SP_IDX_CLK] = ser_clk_i;
        raw_in[SP_IDX_DAT] = ser_dat_i;
        raw_in[SP_IDX_EN]  = ser_en_n_i;
    end

    sp_sync #(
        .WIDTH   (SP_IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    assign sync_clk  = sync_in[SP_IDX_CLK];
    assign sync_dat  = sync_in[SP_IDX_DAT];
    assign sync_en_n = sync_in[SP_IDX_EN];

    sp_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_clk_i  (sync_clk),
        .s_dat_i  (sync_dat),
        .s_en_n_i (sync_en_n),
        .shift_o  (shift_pulse),
        .bit_o    (shift_bit),
        .upd_o    (upd_pulse)
    );

    sp_shift_latch #(
        .WORD_W (WORD_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_pulse),
        .bit_i   (shift_bit),
        .upd_i   (upd_pulse),
        .word_o  (word_o),
        .load_o  (load_o)
    );

endmodule

// File: rtl/serial_prog_port_chk.sv
module serial_prog_port_chk #(
    parameter int WORD_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_clk,
    input logic              s_en_n,
    input logic              shift_pulse,
    input logic              upd_pulse,
    input logic [WORD_W-1:0] word_o,
    input logic              load_o
);

    p_ignore_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |-> (!s_en_n || upd_pulse));

    p_extra_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !s_clk) |-> shift_pulse);

    p_no_extra_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && s_clk) |-> !shift_pulse);

    p_latch_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> load_o);

    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |-> $stable(word_o));

    p_load_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (word_o == '0 && !load_o));

endmodule

bind serial_prog_port serial_prog_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_clk       (sync_clk),
    .s_en_n      (sync_en_n),
    .shift_pulse (shift_pulse),
    .upd_pulse   (upd_pulse),
    .word_o      (word_o),
    .load_o      (load_o)
);

// File: tb/serial_prog_port_bench.sv
module serial_prog_port_bench;

    localparam int W  = 14;
    localparam int PH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_dat = 1'b0;
    logic         ser_en_n = 1'b1;
    logic [W-1:0] word_o;
    logic         load_o;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    logic [W-1:0] exp_sr = '0;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];
    logic [W-1:0] last_word = '0;
    logic         prev_load = 1'b0;

    always #5 clk = ~clk;

    serial_prog_port u_serial_prog_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (ser_clk),
        .ser_dat_i  (ser_dat),
        .ser_en_n_i (ser_en_n),
        .word_o     (word_o),
        .load_o     (load_o)
    );

    task automatic wait_ph();
        repeat (PH) @(negedge clk);
    endtask

    task automatic fail(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        errors++;
        $display("FAIL %s: actual %h expected %h", req, act, exp);
    endtask

    // Driver: sends one frame and pushes the word it should produce
    task automatic burst(input logic [63:0] bits, input int n, input bit end_low,
                         input logic xbit, input string tag);
        if (!end_low && n == 0) begin
            ser_clk = 1'b1;
            wait_ph();
        end
        ser_en_n = 1'b0;
        wait_ph();
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b0;
            ser_dat = bits[i];
            wait_ph();
            ser_clk = 1'b1;
            wait_ph();
            exp_sr = {exp_sr[W-2:0], bits[i]};
        end
        if (end_low) begin
            ser_clk = 1'b0;
            ser_dat = xbit;
            wait_ph();
            exp_sr = {exp_sr[W-2:0], xbit};
        end
        exp_q.push_back(exp_sr);
        tag_q.push_back(tag);
        ser_en_n = 1'b1;
        wait_ph();
        ser_clk = 1'b0;
        wait_ph();
        for (int t = 0; t < 50 && exp_q.size() != 0; t++) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fail({tag, " load missing"}, word_o, exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Monitor: compares each load against the scoreboard
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (load_o) begin
                checks++;
                if (prev_load) begin
                    fail("R7 load longer than one cycle", word_o, last_word);
                end else if (exp_q.size() == 0) begin
                    fail("R1 unexpected load", word_o, last_word);
                end else begin
                    logic [W-1:0] e;
                    string        t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (word_o !== e) fail(t, word_o, e);
                end
            end else begin
                checks++;
                if (word_o !== last_word) fail("R6 word changed without load", word_o, last_word);
            end
            last_word = word_o;
            prev_load = load_o;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] pat;
        repeat (3) @(negedge clk);
        checks++;
        if (word_o !== '0) fail("R8 word in reset", word_o, '0);
        checks++;
        if (load_o !== 1'b0) fail("R8 load in reset", {13'd0, load_o}, '0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if (word_o !== '0 || load_o !== 1'b0) fail("R8 after reset", word_o, '0);
        last_word = word_o;
        mon_on = 1'b1;

        pat = 64'h0000_0000_0000_2D3B;
        burst(pat, 14, 1'b0, 1'b0, "R2 14-bit frame ending clock high");
        pat = 64'h0000_0000_0000_1A5C;
        burst(pat, 14, 1'b1, 1'b1, "R4 frame ending clock low");
        pat = 64'h0000_0000_000F_3C96;
        burst(pat, 20, 1'b0, 1'b0, "R3 20-bit frame");

        // R1: serial activity with the frame closed
        for (int k = 0; k < 6; k++) begin
            ser_dat = k[0];
            ser_clk = 1'b1;
            wait_ph();
            ser_clk = 1'b0;
            wait_ph();
        end
        checks++;
        if (word_o !== exp_sr) fail("R1 idle clocks changed word", word_o, exp_sr);

        pat = 64'h5;
        burst(pat, 3, 1'b0, 1'b0, "R9 R1 short frame keeps older bits");
        burst('0, 0, 1'b1, 1'b1, "R4 frame of only the closing edge");
        burst('0, 0, 1'b0, 1'b0, "R5 closing edge with clock high");
        pat = 64'h9E37_79B9_7F4A_7C15;
        burst(pat, 40, 1'b1, 1'b0, "R3 R4 40-bit frame ending clock low");
        pat = 64'h0000_0000_0000_3FFF;
        burst(pat, 14, 1'b0, 1'b0, "R2 all ones");

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule